// File: doc/BRIEF.md
# Sensor Oscillator Frequency Estimator

This controller estimates the frequency of a free-running clock inside an attached image sensor. The sensor's clock cannot be observed directly. Each measurement run therefore works in three steps. The controller drives a clear pulse into the sensor, then holds the exposure (shutter) line high for a fixed time. It then counts reference-clock ticks from the moment the shutter drops until the sensor raises its data-ready line. The sensor finishes that interval after an uncertain 24 to 26 of its own clock cycles, so a single count only bounds the frequency.

The host starts a batch with a one-cycle `start_i` pulse and gives `runs_log2_i`, the base-2 logarithm of the number of runs. Runs follow each other without a gap. The per-run tick counts are summed, and the average is the sum shifted right. When the batch ends, the block reports the averaged interval in reference ticks. It also reports the two bound numerators, 24 and 26 times the reference frequency word. The host divides each numerator by the averaged tick count to get the lower and upper frequency estimate.

Data-ready is asynchronous to the reference clock. It passes through a multi-stage synchronizer, and the fixed latency of that synchronizer is taken off each count. A per-run timeout ends the batch with an error if data-ready never rises.

Top module: `clkest_ctrl`

## Requirements
- R1: While reset is held and after it is released, `clr_data_o`, `shutter_o`, `busy_o`, `done_o` and `err_o` are low, and `avg_ticks_o`, `lo_num_o` and `hi_num_o` are zero.
- R2: A `start_i` accepted in idle raises `clr_data_o` in the next cycle for exactly CLR_LEN cycles (default 4). `shutter_o` then goes high in the very next cycle for exactly SHUT_LEN cycles (default 8). The two are never high together.
- R3: A run's recorded count is s. Here s is the number of rising reference-clock edges from the edge that drops `shutter_o` up to and including the first edge that samples `data_rdy_i` high (s ≥ 1). The synchronizer delay does not appear in the count.
- R4: A batch is 2^`runs_log2_i` runs. Each further run's clear pulse begins in the cycle after the edge at which the previous run's data-ready rise is detected. Detection happens at edge s + SYNC_N after the shutter drop.
- R5: `avg_ticks_o` is the sum of the recorded counts shifted right by `runs_log2_i`, with the remainder dropped.
- R6: `lo_num_o` = 24 × f and `hi_num_o` = 26 × f, where f is the `f_ref_i` value sampled with the accepted `start_i`. Later changes of `f_ref_i` have no effect on these outputs.
- R7: `done_o` is high for exactly one cycle per batch: two cycles after the last detection edge. The result outputs take their new values in that cycle and hold them until the next `done_o`.
- R8: If no rise is detected by edge TMO_TICKS (default 200) after the shutter drop, the batch stops, `done_o` pulses, `err_o` is 1 and the three result outputs become zero. A rise detected exactly at edge TMO_TICKS is still counted normally.
- R9: `busy_o` is high from the cycle after an accepted start until the last detection or a timeout. A `start_i` seen while busy is ignored and does not add runs or restart the batch.
- R10: A batch that completes without timeout sets `err_o` back to 0 at its `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a batch |
| runs_log2_i | input | RL_W | Log2 of the number of runs in the batch |
| f_ref_i | input | FR_W | Reference frequency word used for the bound numerators |
| data_rdy_i | input | 1 | Sensor data-ready, asynchronous |
| clr_data_o | output | 1 | Clear pulse to the sensor |
| shutter_o | output | 1 | Exposure line to the sensor |
| busy_o | output | 1 | Batch in progress |
| done_o | output | 1 | One-cycle batch completion pulse |
| err_o | output | 1 | Last batch ended by timeout |
| avg_ticks_o | output | CNT_W | Averaged interval in reference ticks |
| lo_num_o | output | FR_W+5 | Lower-bound numerator, 24 × f |
| hi_num_o | output | FR_W+5 | Upper-bound numerator, 26 × f |

## Verification
The bench goes after the smallest interval (s = 1). A design that forgot to remove the synchronizer latency, or removed too much, would report a count off by one or two. It also places a rise exactly on the timeout edge and one edge after it. An off-by-one timeout comparison would either abort a good run or accept a late one. Averages whose sum is not a multiple of the run count expose a rounding average, and a failed batch followed by a good one exposes a sticky error flag. A stray start pulse during a batch, together with a mid-batch change of the frequency word, catches a controller that restarts or samples the reference word late.

// File: rtl/clkest_pkg.sv
package clkest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLR  = 2'd1,
    ST_SHUT = 2'd2,
    ST_MEAS = 2'd3
  } ce_state_e;

endpackage

// File: rtl/clkest_sync.sv
// Multi-flop synchronizer for the sensor's data-ready line plus a rising
// edge detector on the synchronized value. STAGES must be at least 2.
module clkest_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] shreg_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      last_q  <= 1'b0;
    end else begin
      shreg_q <= {shreg_q[STAGES-2:0], async_i};
      last_q  <= shreg_q[STAGES-1];
    end
  end

  assign rise_o = shreg_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/clkest_seq.sv
// Run sequencer: clear pulse, shutter pulse, interval timing, run counting
// and timeout.
module clkest_seq
  import clkest_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RL_W      = 3,
  parameter int FR_W      = 16,
  parameter int SYNC_N    = 2,
  parameter int CLR_LEN   = 4,
  parameter int SHUT_LEN  = 8,
  parameter int TMO_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [RL_W-1:0]  runs_log2_i,
  input  logic [FR_W-1:0]  f_ref_i,
  input  logic             rise_i,
  output logic             clr_o,
  output logic             shut_o,
  output logic             busy_o,
  output logic             open_o,
  output logic             smp_vld_o,
  output logic [CNT_W-1:0] smp_ticks_o,
  output logic             fin_o,
  output logic             tmo_o,
  output logic [RL_W-1:0]  rl_o,
  output logic [FR_W-1:0]  fr_o
);

  localparam int RUN_W = (1 << RL_W);
  localparam int LAT   = SYNC_N - 1;
  localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(CLR_LEN - 1);
  localparam logic [CNT_W-1:0] SHUT_LAST = CNT_W'(SHUT_LEN - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_TICKS - 1);
  localparam logic [CNT_W-1:0] LAT_W     = CNT_W'(LAT);

  ce_state_e        st_q;
  logic [CNT_W-1:0] ph_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic [RUN_W-1:0] run_goal;
  logic [CNT_W-1:0] ticks_nxt;

  assign run_nxt   = run_q + 1'b1;
  assign run_goal  = RUN_W'(1) << rl_o;
  assign ticks_nxt = (ph_q >= LAT_W) ? (ph_q - LAT_W) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      ph_q        <= '0;
      run_q       <= '0;
      rl_o        <= '0;
      fr_o        <= '0;
      open_o      <= 1'b0;
      smp_vld_o   <= 1'b0;
      smp_ticks_o <= '0;
      fin_o       <= 1'b0;
      tmo_o       <= 1'b0;
    end else begin
      open_o    <= 1'b0;
      smp_vld_o <= 1'b0;
      fin_o     <= 1'b0;
      tmo_o     <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_CLR;
            ph_q   <= '0;
            run_q  <= '0;
            rl_o   <= runs_log2_i;
            fr_o   <= f_ref_i;
            open_o <= 1'b1;
          end
        end
        ST_CLR: begin
          if (ph_q == CLR_LAST) begin
            st_q <= ST_SHUT;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_SHUT: begin
          if (ph_q == SHUT_LAST) begin
            st_q <= ST_MEAS;
            ph_q <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        ST_MEAS: begin
          if (rise_i) begin
            smp_vld_o   <= 1'b1;
            smp_ticks_o <= ticks_nxt;
            ph_q        <= '0;
            run_q       <= run_nxt;
            if (run_nxt == run_goal) begin
              st_q  <= ST_IDLE;
              fin_o <= 1'b1;
            end else begin
              st_q <= ST_CLR;
            end
          end else if (ph_q == TMO_LAST) begin
            st_q  <= ST_IDLE;
            ph_q  <= '0;
            tmo_o <= 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o  = (st_q == ST_CLR);
  assign shut_o = (st_q == ST_SHUT);
  assign busy_o = (st_q != ST_IDLE);

  AST_CLR_THEN_SHUT: assert property (@(posedge clk) disable iff (rst)
    $fell(clr_o) |-> shut_o); // R2
  AST_FIN_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> smp_vld_o); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !open_o); // R9
  AST_FIN_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fin_o && tmo_o)); // R8

endmodule

// File: rtl/clkest_acc.sv
// Sums per-run counts and forms the averaged result and bound numerators.
module clkest_acc #(
  parameter int CNT_W  = 16,
  parameter int RL_W   = 3,
  parameter int FR_W   = 16,
  parameter int LO_CYC = 24,
  parameter int HI_CYC = 26,
  parameter int BND_W  = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             smp_vld_i,
  input  logic [CNT_W-1:0] smp_ticks_i,
  input  logic             fin_i,
  input  logic             tmo_i,
  input  logic [RL_W-1:0]  rl_i,
  input  logic [FR_W-1:0]  fr_i,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] avg_o,
  output logic [BND_W-1:0] lo_o,
  output logic [BND_W-1:0] hi_o
);

  localparam int ACC_W = CNT_W + (1 << RL_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_nxt;
  logic [ACC_W-1:0] avg_full;

  assign sum_nxt  = acc_q + (smp_vld_i ? ACC_W'(smp_ticks_i) : '0);
  assign avg_full = sum_nxt >> rl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      avg_o  <= '0;
      lo_o   <= '0;
      hi_o   <= '0;
    end else begin
      done_o <= fin_i | tmo_i;
      if (open_i) begin
        acc_q <= '0;
      end else if (smp_vld_i) begin
        acc_q <= sum_nxt;
      end
      if (fin_i) begin
        avg_o <= CNT_W'(avg_full);
        lo_o  <= BND_W'(fr_i) * BND_W'(LO_CYC);
        hi_o  <= BND_W'(fr_i) * BND_W'(HI_CYC);
        err_o <= 1'b0;
      end else if (tmo_i) begin
        avg_o <= '0;
        lo_o  <= '0;
        hi_o  <= '0;
        err_o <= 1'b1;
      end
    end
  end

  AST_TMO_REPORT: assert property (@(posedge clk) disable iff (rst)
    tmo_i |=> (done_o && err_o)); // R8
  AST_FIN_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
    fin_i |=> (done_o && !err_o)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

endmodule

// File: rtl/clkest_ctrl.sv
// Top: sensor oscillator frequency estimator.
module clkest_ctrl #(
  parameter int CNT_W     = 16,
  parameter int RL_W      = 3,
  parameter int FR_W      = 16,
  parameter int SYNC_N    = 2,
  parameter int CLR_LEN   = 4,
  parameter int SHUT_LEN  = 8,
  parameter int TMO_TICKS = 200,
  parameter int LO_CYC    = 24,
  parameter int HI_CYC    = 26,
  localparam int BND_W    = FR_W + $clog2(HI_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [RL_W-1:0]  runs_log2_i,
  input  logic [FR_W-1:0]  f_ref_i,
  input  logic             data_rdy_i,
  output logic             clr_data_o,
  output logic             shutter_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] avg_ticks_o,
  output logic [BND_W-1:0] lo_num_o,
  output logic [BND_W-1:0] hi_num_o
);

  logic             rise;
  logic             open_p;
  logic             smp_vld;
  logic [CNT_W-1:0] smp_ticks;
  logic             fin_p;
  logic             tmo_p;
  logic [RL_W-1:0]  rl_q;
  logic [FR_W-1:0]  fr_q;

  clkest_sync #(
    .STAGES (SYNC_N)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (data_rdy_i),
    .rise_o  (rise)
  );

  clkest_seq #(
    .CNT_W     (CNT_W),
    .RL_W      (RL_W),
    .FR_W      (FR_W),
    .SYNC_N    (SYNC_N),
    .CLR_LEN   (CLR_LEN),
    .SHUT_LEN  (SHUT_LEN),
    .TMO_TICKS (TMO_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .runs_log2_i (runs_log2_i),
    .f_ref_i     (f_ref_i),
    .rise_i      (rise),
    .clr_o       (clr_data_o),
    .shut_o      (shutter_o),
    .busy_o      (busy_o),
    .open_o      (open_p),
    .smp_vld_o   (smp_vld),
    .smp_ticks_o (smp_ticks),
    .fin_o       (fin_p),
    .tmo_o       (tmo_p),
    .rl_o        (rl_q),
    .fr_o        (fr_q)
  );

  clkest_acc #(
    .CNT_W  (CNT_W),
    .RL_W   (RL_W),
    .FR_W   (FR_W),
    .LO_CYC (LO_CYC),
    .HI_CYC (HI_CYC),
    .BND_W  (BND_W)
  ) u_acc (
    .clk         (clk),
    .rst         (rst),
    .open_i      (open_p),
    .smp_vld_i   (smp_vld),
    .smp_ticks_i (smp_ticks),
    .fin_i       (fin_p),
    .tmo_i       (tmo_p),
    .rl_i        (rl_q),
    .fr_i        (fr_q),
    .done_o      (done_o),
    .err_o       (err_o),
    .avg_o       (avg_ticks_o),
    .lo_o        (lo_num_o),
    .hi_o        (hi_num_o)
  );

endmodule

// File: tb/clkest_ctrl_tb.sv
module clkest_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int RL_W  = 3;
  localparam int FR_W  = 16;
  localparam int SYN   = 2;
  localparam int CLRL  = 4;
  localparam int SHL   = 8;
  localparam int TMO   = 200;
  localparam int BND_W = FR_W + 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [RL_W-1:0]  rl = '0;
  logic [FR_W-1:0]  fref = '0;
  logic             dr = 1'b0;
  logic             clr_data_o, shutter_o, busy_o, done_o, err_o;
  logic [CNT_W-1:0] avg_ticks_o;
  logic [BND_W-1:0] lo_num_o, hi_num_o;

  int n_vec = 0;
  int n_fail = 0;
  int dly[256];
  int sr = 0;
  int clr_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkest_ctrl #(
    .CNT_W(CNT_W), .RL_W(RL_W), .FR_W(FR_W), .SYNC_N(SYN),
    .CLR_LEN(CLRL), .SHUT_LEN(SHL), .TMO_TICKS(TMO)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .runs_log2_i(rl), .f_ref_i(fref),
    .data_rdy_i(dr), .clr_data_o(clr_data_o), .shutter_o(shutter_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .avg_ticks_o(avg_ticks_o), .lo_num_o(lo_num_o), .hi_num_o(hi_num_o)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Sensor model: clears data-ready on the clear pulse, raises it a programmed
  // number of edges after the shutter drops (0 = never).
  int  s_cnt = -1;
  int  s_cur = 0;
  bit  sh_prev = 1'b0;
  bit  clr_prev = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      dr = 1'b0; s_cnt = -1; s_cur = 0; sh_prev = 1'b0; clr_prev = 1'b0;
    end else begin
      if (clr_data_o) begin dr = 1'b0; s_cnt = -1; end
      if (clr_data_o && !clr_prev) clr_pulses++;
      if (sh_prev && !shutter_o) begin
        s_cur = dly[sr]; sr++; s_cnt = 0;
      end else if (s_cnt >= 0) begin
        s_cnt++;
      end
      if (s_cnt >= 0 && s_cur != 0 && s_cnt == s_cur - 1) begin
        dr = 1'b1; s_cnt = -1;
      end
      sh_prev = shutter_o;
      clr_prev = clr_data_o;
    end
  end

  // Behavioural reference model, advanced on each rising edge.
  int     m_ph = 0, m_k = 0, m_s = 0, m_ri = 0, m_runs = 0, m_rl = 0, m_gi = 0;
  longint m_sum = 0, m_f = 0;
  bit     m_pend = 0, m_pend_err = 0;
  bit     e_done = 0, e_err = 0;
  longint e_avg = 0, e_lo = 0, e_hi = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_k = 0; m_pend = 0; e_done = 0; e_err = 0;
      e_avg = 0; e_lo = 0; e_hi = 0; m_gi = 0;
    end else begin
      e_done = 0;
      if (m_pend) begin
        e_done = 1; m_pend = 0;
        if (m_pend_err) begin
          e_err = 1; e_avg = 0; e_lo = 0; e_hi = 0;
        end else begin
          e_err = 0; e_avg = m_sum >> m_rl; e_lo = 24 * m_f; e_hi = 26 * m_f;
        end
      end
      case (m_ph)
        0: if (start) begin
             m_ph = 1; m_k = 0; m_rl = int'(rl); m_runs = 1 << m_rl;
             m_sum = 0; m_f = longint'(fref); m_ri = 0;
           end
        1: begin m_k++; if (m_k == CLRL) begin m_ph = 2; m_k = 0; end end
        2: begin
             m_k++;
             if (m_k == SHL) begin m_ph = 3; m_k = 0; m_s = dly[m_gi]; m_gi++; end
           end
        default: begin
          m_k++;
          if (m_s != 0 && m_k == m_s + SYN) begin
            m_sum += m_s; m_ri++;
            if (m_ri == m_runs) begin m_ph = 0; m_pend = 1; m_pend_err = 0; end
            else begin m_ph = 1; m_k = 0; end
          end else if (m_k == TMO) begin
            m_ph = 0; m_pend = 1; m_pend_err = 1;
          end
        end
      endcase
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "clr_data_o", clr_data_o, m_ph == 1);
      chk("R2", "shutter_o", shutter_o, m_ph == 2);
      chk("R9", "busy_o", busy_o, m_ph != 0);
      chk("R7", "done_o", done_o, e_done);
      chk("R5", "avg_ticks_o", avg_ticks_o, e_avg);
      chk("R6", "lo_num_o", lo_num_o, e_lo);
      chk("R6", "hi_num_o", hi_num_o, e_hi);
      chk("R8", "err_o", err_o, e_err);
    end
  end

  task automatic go(int lg, int f);
    @(negedge clk);
    start = 1'b1; rl = RL_W'(lg); fref = FR_W'(f);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (done_o !== 1'b1 && k < 20000) begin
      @(negedge clk); k++;
    end
    if (k >= 20000) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL global watchdog: actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int base;
    foreach (dly[i]) dly[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "avg in reset", avg_ticks_o, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "clr after reset", clr_data_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "hi after reset", hi_num_o, 0);

    // single run
    dly[sr] = 10;
    go(0, 100); wait_done();
    chk("R3", "single run count", avg_ticks_o, 10);
    chk("R6", "lo single", lo_num_o, 2400);
    chk("R6", "hi single", hi_num_o, 2600);

    // minimum interval
    dly[sr] = 1;
    go(0, 7); wait_done();
    chk("R3", "minimum interval", avg_ticks_o, 1);

    // four runs, truncating average
    base = sr;
    for (int i = 0; i < 4; i++) dly[base + i] = 10 + i;
    go(2, 500); wait_done();
    chk("R5", "floor average 46/4", avg_ticks_o, 11);

    // eight runs, count clear pulses
    base = sr; clr_pulses = 0;
    for (int i = 0; i < 8; i++) dly[base + i] = 3 + 5 * i;
    go(3, 65535); wait_done();
    chk("R4", "clear pulses for 8 runs", clr_pulses, 8);
    chk("R5", "average of 8", avg_ticks_o, (8 * 3 + 5 * 28) >> 3);
    chk("R6", "hi at max fref", hi_num_o, 26 * 65535);

    // timeout on second run
    base = sr;
    dly[base] = 20; dly[base + 1] = 0;
    go(1, 300); wait_done();
    chk("R8", "timeout err", err_o, 1);
    chk("R8", "timeout avg zero", avg_ticks_o, 0);

    // recovery clears error
    dly[sr] = 50;
    go(0, 300); wait_done();
    chk("R10", "err cleared", err_o, 0);
    chk("R10", "avg after recovery", avg_ticks_o, 50);

    // rise detected exactly at timeout edge is counted
    dly[sr] = TMO - SYN;
    go(0, 1); wait_done();
    chk("R8", "boundary accepted err", err_o, 0);
    chk("R8", "boundary accepted avg", avg_ticks_o, TMO - SYN);

    // one edge later times out
    dly[sr] = TMO - SYN + 1;
    go(0, 1); wait_done();
    chk("R8", "boundary late err", err_o, 1);

    // start while busy ignored; fref change mid-batch has no effect
    base = sr; clr_pulses = 0;
    for (int i = 0; i < 4; i++) dly[base + i] = 25;
    for (int i = 4; i < 8; i++) dly[base + i] = 90;
    go(2, 40);
    repeat (30) @(negedge clk);
    start = 1'b1; rl = 3'd3; fref = 16'd999;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R9", "runs after stray start", clr_pulses, 4);
    chk("R9", "avg after stray start", avg_ticks_o, 25);
    chk("R6", "lo uses start-time fref", lo_num_o, 24 * 40);

    // sixteen runs
    base = sr;
    for (int i = 0; i < 16; i++) dly[base + i] = 2 + (i * 7) % 13;
    go(4, 1234); wait_done();
    chk("R7", "done pulse seen", done_o, 1);
    @(negedge clk);
    chk("R7", "done single cycle", done_o, 0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule